// File: doc/BRIEF.md
# Guarded Register Update with Fault Injection

This block holds one register that a guarded statement updates: on a cycle where an evaluation is requested and the guard is true, the register takes the bitwise complement of the data input. A test controller can make the block misbehave in a chosen way while a test sequence runs. It can hold the guard true or false, or force the masked bits of the assigned value to one or to zero. Comparing the output trace of a faulty run with a fault-free run tells whether the sequence exposes that fault.

Two single-cycle event outputs report statement execution to an outside coverage counter. The first marks that the guard was evaluated. The second marks that the guarded assignment ran. Both stay quiet on the paths that bypass the normal statement flow. Mode, mask, guard and data are all sampled on the same rising edge. The register and the events change together one edge after the request.

Top module: `guard_fault_wrap`

## Requirements
- R1: A synchronous active-high reset clears q, ev_cond and ev_assign at the next rising edge.
- R2: With mode 0 (no fault), an edge where eval=1 and cond=1 loads q with ~data, and an edge where eval=1 and cond=0 leaves q unchanged.
- R3: Mode codes 5, 6 and 7 behave exactly as mode 0 for q and for both event outputs.
- R4: With mode 1 (guard held true), an edge with eval=1 loads q with ~data whatever cond is.
- R5: With mode 2 (guard held false), an edge with eval=1 leaves q unchanged whatever cond is.
- R6: With mode 3 (bits forced to one), an edge with eval=1 and cond=1 loads q with (~data) | mask. Each set bit of mask selects a faulted position.
- R7: With mode 4 (bits forced to zero), an edge with eval=1 and cond=1 loads q with (~data) & ~mask.
- R8: In modes 3 and 4, an edge with eval=1 and cond=0 leaves q unchanged.
- R9: ev_cond is 1 for the single cycle after an edge with eval=1 and mode not 1 or 2; otherwise it is 0.
- R10: ev_assign is 1 for the single cycle after an edge with eval=1, cond=1 and mode 0, 5, 6 or 7; otherwise it is 0.
- R11: An edge with eval=0 leaves q unchanged and drives both event outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| eval | input | 1 | Request to evaluate the guarded statement this edge |
| cond | input | 1 | Guard condition |
| data | input | W | Operand; the assigned value is its complement |
| mode | input | 3 | Fault selection: 0 none, 1 guard true, 2 guard false, 3 bits to one, 4 bits to zero, 5-7 none |
| mask | input | W | Bit positions affected by modes 3 and 4 |
| q | output | W | Register contents |
| ev_cond | output | 1 | Guard-evaluated event pulse |
| ev_assign | output | 1 | Fault-free assignment event pulse |

## Verification
The only state is q and the two event flops, so a wrong update shows at the ports on the cycle right after the faulty edge. A missed or spurious load changes q there. A wrong event decision shows on ev_cond or ev_assign on the same cycle. A wrongly held q persists and keeps differing from the model until the next load, so checking on every cycle catches it at the first edge. Corrupted bits under a mask mismatch only in the masked positions. The checks therefore sweep dense and sparse masks against data patterns that set both polarities.

// File: rtl/guard_fault_wrap.sv
module guard_fault_wrap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         eval,
  input  logic         cond,
  input  logic [W-1:0] data,
  input  logic [2:0]   mode,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q,
  output logic         ev_cond,
  output logic         ev_assign
);
  localparam logic [2:0] M_CT = 3'd1;
  localparam logic [2:0] M_CF = 3'd2;
  localparam logic [2:0] M_B1 = 3'd3;
  localparam logic [2:0] M_B0 = 3'd4;

  logic [W-1:0] calc, val;
  logic guard_forced, fault_free, take;

  assign calc         = ~data;
  assign guard_forced = (mode == M_CT) || (mode == M_CF);
  assign fault_free   = !guard_forced && (mode != M_B1) && (mode != M_B0);
  assign take         = eval && ((mode == M_CT) || ((mode != M_CF) && cond));

  always_comb begin
    case (mode)
      M_B1:    val = calc | mask;
      M_B0:    val = calc & ~mask;
      default: val = calc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q         <= '0;
      ev_cond   <= 1'b0;
      ev_assign <= 1'b0;
    end else begin
      if (take) q <= val;
      ev_cond   <= eval && !guard_forced;
      ev_assign <= eval && cond && fault_free;
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (q == '0 && !ev_cond && !ev_assign));

  // R11
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !eval |=> ($stable(q) && !ev_cond && !ev_assign));

  // R5
  guard_false_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (eval && mode == M_CF) |=> ($stable(q) && !ev_cond && !ev_assign));

  // R4
  guard_true_loads_chk: assert property (@(posedge clk) disable iff (rst)
    (eval && mode == M_CT) |=> (q == ~$past(data) && !ev_cond));

  // R6
  force_one_chk: assert property (@(posedge clk) disable iff (rst)
    (eval && cond && mode == M_B1) |=> ((q & $past(mask)) == $past(mask)));

  // R7
  force_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (eval && cond && mode == M_B0) |=> ((q & $past(mask)) == '0));

  // R10
  assign_implies_eval_chk: assert property (@(posedge clk) disable iff (rst)
    ev_assign |-> ev_cond);
endmodule

// File: tb/test_guard_fault_wrap.sv
module test_guard_fault_wrap;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, eval, cond;
  logic [W-1:0] data, mask;
  logic [2:0] mode;
  logic [W-1:0] q;
  logic ev_cond, ev_assign;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [W-1:0] exp_q;
  logic exp_ec, exp_ea;

  always #2.5 clk = ~clk;

  guard_fault_wrap #(.W(W)) i_guard_fault_wrap (
    .clk(clk), .rst(rst), .eval(eval), .cond(cond), .data(data),
    .mode(mode), .mask(mask), .q(q), .ev_cond(ev_cond), .ev_assign(ev_assign)
  );

  function automatic string tag_of(int m, bit e, bit c);
    if (!e) return "R11";
    case (m)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return c ? "R6" : "R8";
      4: return c ? "R7" : "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic compare(string tag);
    vectors++;
    if (q !== exp_q) begin
      miscompares++;
      $display("FAIL %s q=%h expected %h", tag, q, exp_q);
    end
    if (ev_cond !== exp_ec) begin
      miscompares++;
      $display("FAIL %s/R9 ev_cond=%b expected %b", tag, ev_cond, exp_ec);
    end
    if (ev_assign !== exp_ea) begin
      miscompares++;
      $display("FAIL %s/R10 ev_assign=%b expected %b", tag, ev_assign, exp_ea);
    end
  endtask

  task automatic apply(bit r, bit e, bit c, logic [W-1:0] d, int m, logic [W-1:0] k, string tag);
    @(negedge clk);
    rst = r; eval = e; cond = c; data = d; mode = 3'(m); mask = k;
    @(posedge clk);
    #1;
    if (r) begin
      exp_q = '0; exp_ec = 0; exp_ea = 0;
    end else begin
      bit fires;
      logic [W-1:0] v;
      v = ~d;
      fires = 0;
      if (e) begin
        if (m == 1) fires = 1;
        else if (m == 2) fires = 0;
        else fires = c;
        if (m == 3) v = v | k;
        if (m == 4) v = v & ~k;
      end
      if (fires) exp_q = v;
      exp_ec = e && (m != 1) && (m != 2);
      exp_ea = e && c && (m == 0 || m > 4);
    end
    compare(tag);
  endtask

  initial begin
    rst = 1; eval = 0; cond = 0; data = '0; mode = '0; mask = '0;
    exp_q = '0; exp_ec = 0; exp_ea = 0;
    apply(1, 1, 1, 8'h5A, 0, 8'h00, "R1");
    apply(0, 1, 1, 8'h0F, 0, 8'h00, "R2");
    apply(0, 1, 0, 8'h33, 0, 8'h00, "R2");
    apply(0, 0, 1, 8'h00, 0, 8'h00, "R11");
    apply(0, 1, 0, 8'hA5, 1, 8'h00, "R4");
    apply(0, 1, 1, 8'h3C, 2, 8'hFF, "R5");
    apply(0, 1, 0, 8'h3C, 2, 8'hFF, "R5");
    apply(0, 1, 1, 8'hFF, 3, 8'h81, "R6");
    apply(0, 1, 1, 8'h00, 4, 8'h18, "R7");
    apply(0, 1, 0, 8'h55, 3, 8'hFF, "R8");
    apply(0, 1, 0, 8'h55, 4, 8'hFF, "R8");
    apply(0, 1, 1, 8'h12, 5, 8'hFF, "R3");
    apply(0, 1, 1, 8'h34, 6, 8'hFF, "R3");
    apply(0, 1, 1, 8'h56, 7, 8'hFF, "R3");
    apply(0, 1, 0, 8'h78, 7, 8'hFF, "R3");
    apply(0, 0, 1, 8'h99, 1, 8'hFF, "R11");
    apply(0, 1, 1, 8'h6E, 0, 8'h00, "R9");
    apply(1, 0, 0, 8'h00, 0, 8'h00, "R1");
    for (int i = 0; i < 400; i++) begin
      bit e, c;
      int m;
      logic [W-1:0] d, k;
      e = ($urandom % 4) != 0;
      c = $urandom % 2;
      m = $urandom % 8;
      d = W'($urandom);
      k = (i % 3 == 0) ? W'(1 << (i % W)) : W'($urandom);
      apply(($urandom % 50) == 0, e, c, d, m, k, tag_of(m, e, c));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired q=%h expected %h", q, exp_q);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule